// File: doc/BRIEF.md
# Dual Interval Timer

This block provides two up-counting interval timers that share one control register. Timer A has a 10-bit period and advances once per sample tick. Timer B has an 8-bit period and advances once per sixteen sample ticks. A timer starts counting from its loaded period. When it passes its all-ones value it overflows, reloads the period and keeps running.

Each timer has its own run control and its own flag enable. Each also has a clear strobe that acts for one write only. When a timer overflows with its flag enabled, a sticky status flag is set. Both flags appear in a status byte, and an interrupt line is high while either flag is set. The control register also holds a two-bit mode field for the third synthesis channel. This block only stores that field and drives it out.

Software loads the registers through a single-cycle address/data write strobe. The sample tick comes from the surrounding synthesizer.

Top module: `ivt_dual_timer`

## Requirements
- R1: A write to address 0x24 sets Timer A period bits 9..2 from data bits 7..0. A write to 0x25 sets period bits 1..0 from data bits 1..0. Neither write changes the other part of the period.
- R2: A write to address 0x26 sets the 8-bit Timer B period. A write to any address other than 0x24..0x27 has no effect on period, control, flags or outputs.
- R3: In the control register at 0x27, bit 0 runs Timer A when 1 and stops it when 0. Bit 1 does the same for Timer B. Starting a stopped timer loads its period into the count. Stopping a timer freezes the count and leaves the flags unchanged.
- R4: A running Timer A adds one per sample tick. On a tick that finds the count at 1023, it overflows and reloads the period. From a start with period P, the first overflow therefore falls on tick 1024-P.
- R5: A running Timer B adds one per 16 sample ticks. Its tick divider restarts when the timer starts. With period P, the first overflow falls on sample tick 16*(256-P).
- R6: Control bit 2 lets a Timer A overflow set flag A, and bit 3 does the same for Timer B. When the bit is 0, an overflow leaves the flag unchanged.
- R7: A control write with bit 4 at 1 clears flag A, and bit 5 at 1 clears flag B. Writing 0 to these bits has no effect, and neither bit is stored.
- R8: When a clear strobe and an overflow of the same timer fall in the same cycle, the flag ends up 0.
- R9: Status bit 0 is flag A and bit 1 is flag B, and bits 7..2 are 0. The irq output is 1 exactly while either flag is 1.
- R10: Control bits 7..6 are stored and driven on ch3_mode (0 normal, 1 special). The field changes only on a control write.
- R11: While rst_n is low, both timers are stopped, all registers are zero, and status, irq and ch3_mode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| sample_tick | input | 1 | One pulse per output sample |
| status | output | 8 | Flag byte: bit 0 Timer A, bit 1 Timer B |
| irq | output | 1 | High while any flag is set |
| ch3_mode | output | 2 | Stored channel-3 mode field |

## Verification
The assertions check on every cycle:
- a flag rises only after an enabled overflow of its own timer;
- a clear strobe always leaves its flag at 0 on the next cycle;
- a stopped Timer A keeps its count;
- a running Timer A steps by exactly one per tick below its top value;
- irq and the status padding stay consistent;
- the mode field moves only on control writes.

Overflow spacing needs the bench's scenarios to show it: the 1024-P tick count, the sixteen-tick divider of Timer B, and reloading on restart as opposed to resuming.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_A_HI = 8'h24;
    localparam logic [ADDR_W-1:0] ADR_A_LO = 8'h25;
    localparam logic [ADDR_W-1:0] ADR_B    = 8'h26;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h27;

    localparam int unsigned CB_RUN_A = 0;
    localparam int unsigned CB_RUN_B = 1;
    localparam int unsigned CB_EN_A  = 2;
    localparam int unsigned CB_EN_B  = 3;
    localparam int unsigned CB_CLR_A = 4;
    localparam int unsigned CB_CLR_B = 5;
    localparam int unsigned CB_MODE  = 6;

    typedef struct packed {
        logic [1:0] mode;
        logic       en_b;
        logic       en_a;
        logic       run_b;
        logic       run_a;
    } ivt_ctrl_t;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned A_W = 10,
    parameter int unsigned B_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [A_W-1:0]    period_a,
    output logic [B_W-1:0]    period_b,
    output ivt_ctrl_t         ctrl,
    output logic              load_a,
    output logic              load_b,
    output logic              clr_a,
    output logic              clr_b
);
    localparam int unsigned LO_W = A_W - DATA_W;

    typedef struct packed {
        logic [A_W-1:0] period_a;
        logic [B_W-1:0] period_b;
        ivt_ctrl_t      ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_a = 1'b0;
        load_b = 1'b0;
        clr_a  = 1'b0;
        clr_b  = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADR_A_HI: st_d.period_a[A_W-1:LO_W] = wr_data;
                ADR_A_LO: st_d.period_a[LO_W-1:0]   = wr_data[LO_W-1:0];
                ADR_B:    st_d.period_b             = wr_data[B_W-1:0];
                ADR_CTRL: begin
                    st_d.ctrl.run_a = wr_data[CB_RUN_A];
                    st_d.ctrl.run_b = wr_data[CB_RUN_B];
                    st_d.ctrl.en_a  = wr_data[CB_EN_A];
                    st_d.ctrl.en_b  = wr_data[CB_EN_B];
                    st_d.ctrl.mode  = wr_data[CB_MODE+1:CB_MODE];
                    // a start only reloads a timer that was stopped
                    load_a = wr_data[CB_RUN_A] & ~st_q.ctrl.run_a;
                    load_b = wr_data[CB_RUN_B] & ~st_q.ctrl.run_b;
                    clr_a  = wr_data[CB_CLR_A];
                    clr_b  = wr_data[CB_CLR_B];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_a = st_q.period_a;
    assign period_b = st_q.period_b;
    assign ctrl     = st_q.ctrl;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int unsigned W        = 10,
    parameter int unsigned PRESCALE = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] period,
    output logic         ovf,
    output logic [W-1:0] count
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic         step;
    logic [W-1:0] cnt_d, cnt_q;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam logic [PW-1:0] DIV_TOP = PW'(PRESCALE - 1);
            logic [PW-1:0] div_d, div_q;

            always_comb begin
                div_d = div_q;
                if (load)
                    div_d = '0;
                else if (run && tick)
                    div_d = (div_q == DIV_TOP) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign step = run && tick && !load && (div_q == DIV_TOP);
        end else begin : g_direct
            assign step = run && tick && !load;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        ovf   = 1'b0;
        if (load) begin
            cnt_d = period;
        end else if (step) begin
            if (cnt_q == '1) begin
                ovf   = 1'b1;
                cnt_d = period;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ivt_flags.sv
module ivt_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ovf,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flag_d[i] = flag_q[i];
            if (ovf[i] && en[i]) flag_d[i] = 1'b1;
            if (clr[i])          flag_d[i] = 1'b0;   // clear beats overflow
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/ivt_dual_timer.sv
module ivt_dual_timer
    import ivt_pkg::*;
#(
    parameter int unsigned A_W        = 10,
    parameter int unsigned B_W        = 8,
    parameter int unsigned B_PRESCALE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sample_tick,
    output logic [DATA_W-1:0] status,
    output logic              irq,
    output logic [1:0]        ch3_mode
);
    localparam int unsigned NT = 2;

    logic [A_W-1:0] period_a, cnt_a;
    logic [B_W-1:0] period_b, cnt_b;
    ivt_ctrl_t      ctrl;
    logic           load_a, load_b, clr_a, clr_b;
    logic           ovf_a, ovf_b;
    logic [NT-1:0]  flags;

    ivt_regs #(.A_W(A_W), .B_W(B_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .period_a(period_a), .period_b(period_b),
        .ctrl(ctrl), .load_a(load_a), .load_b(load_b),
        .clr_a(clr_a), .clr_b(clr_b)
    );

    ivt_counter #(.W(A_W), .PRESCALE(1)) cnt_a_i (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .run(ctrl.run_a),
        .load(load_a), .period(period_a), .ovf(ovf_a), .count(cnt_a)
    );

    ivt_counter #(.W(B_W), .PRESCALE(B_PRESCALE)) cnt_b_i (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .run(ctrl.run_b),
        .load(load_b), .period(period_b), .ovf(ovf_b), .count(cnt_b)
    );

    ivt_flags #(.N(NT)) flags_i (
        .clk(clk), .rst_n(rst_n),
        .ovf({ovf_b, ovf_a}), .en({ctrl.en_b, ctrl.en_a}),
        .clr({clr_b, clr_a}), .flag(flags)
    );

    assign status   = {{(DATA_W-NT){1'b0}}, flags};
    assign irq      = |flags;
    assign ch3_mode = ctrl.mode;

    logic unused_b;
    assign unused_b = ^cnt_b;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int unsigned A_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              sample_tick,
    input logic [DATA_W-1:0] status,
    input logic              irq,
    input logic [1:0]        ch3_mode,
    input logic              ovf_a,
    input logic              ovf_b,
    input logic              en_a,
    input logic              en_b,
    input logic              clr_a,
    input logic              clr_b,
    input logic              run_a,
    input logic              load_a,
    input logic [A_W-1:0]    cnt_a
);
    assert_flag_a_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(ovf_a && en_a));
    assert_flag_b_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(ovf_b && en_b));
    assert_clear_a_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_a |=> !status[0]);
    assert_clear_b_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_b |=> !status[1]);
    assert_stopped_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_a && !load_a) |=> $stable(cnt_a));
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_a && sample_tick && !load_a && cnt_a != '1) |=> cnt_a == A_W'($past(cnt_a) + 1'b1));
    assert_irq_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status[0] || status[1]));
    assert_status_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status[DATA_W-1:2] == '0);
    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_CTRL) |=> $stable(ch3_mode));
endmodule

bind ivt_dual_timer ivt_checker #(.A_W(A_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .sample_tick(sample_tick), .status(status), .irq(irq), .ch3_mode(ch3_mode),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .en_a(ctrl.en_a), .en_b(ctrl.en_b),
    .clr_a(clr_a), .clr_b(clr_b), .run_a(ctrl.run_a), .load_a(load_a),
    .cnt_a(cnt_a)
);

// File: tb/ivt_dual_timer_tb_top.sv
module ivt_dual_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick = 1'b0;
    logic [7:0] status;
    logic       irq;
    logic [1:0] ch3_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ivt_dual_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_tick(sample_tick), .status(status),
        .irq(irq), .ch3_mode(ch3_mode)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [7:0]  data;
        logic [15:0] ticks;
        logic [7:0]  exp_st;
        logic [1:0]  exp_mode;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h24, 8'hFF, 16'd0,  8'h00, 2'd0},  // R1 period A upper -> 0x3FC
        '{8'h25, 8'h02, 16'd0,  8'h00, 2'd0},  // R1 period A lower -> 0x3FE
        '{8'h27, 8'h05, 16'd1,  8'h00, 2'd0},  // R3 start A: 3FE -> 3FF
        '{8'h26, 8'h00, 16'd1,  8'h01, 2'd0},  // R4 overflow on tick 2
        '{8'h27, 8'h15, 16'd0,  8'h00, 2'd0},  // R7 clear A, no reload
        '{8'h27, 8'h01, 16'd2,  8'h00, 2'd0},  // R6 overflow with enable off
        '{8'h27, 8'h05, 16'd2,  8'h01, 2'd0},  // R6 overflow with enable on
        '{8'h27, 8'h04, 16'd5,  8'h01, 2'd0},  // R3 stopped: flag held
        '{8'h27, 8'h14, 16'd0,  8'h00, 2'd0},  // R7 clear while stopped
        '{8'h26, 8'hFF, 16'd0,  8'h00, 2'd0},  // R2 period B = 255
        '{8'h27, 8'h0A, 16'd15, 8'h00, 2'd0},  // R5 15 ticks: no overflow
        '{8'h28, 8'h55, 16'd1,  8'h02, 2'd0},  // R5 tick 16 overflows; R2 0x28 ignored
        '{8'h27, 8'h4A, 16'd16, 8'h02, 2'd1},  // R10 special mode stored
        '{8'h27, 8'h6A, 16'd0,  8'h00, 2'd1}   // R7 clear B
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] exp_st, input logic [1:0] exp_mode);
        check8({req, " status"}, status, exp_st);
        check8({"R9 irq / ", req}, {7'd0, irq}, {7'd0, |exp_st});
        check8({"R10 mode / ", req}, {6'd0, ch3_mode}, {6'd0, exp_mode});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sample_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; sample_tick = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sample_tick = 1'b1;
            @(negedge clk);
        end
        sample_tick = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R11 reset", 8'h00, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            do_write(VECS[v].addr, VECS[v].data, 1'b0);
            run_ticks(int'(VECS[v].ticks));
            check_all($sformatf("vector %0d", v), VECS[v].exp_st, VECS[v].exp_mode);
        end

        // R8: clear strobe and Timer A overflow in the same cycle
        do_write(8'h27, 8'h00, 1'b0);
        do_write(8'h24, 8'hFF, 1'b0);
        do_write(8'h25, 8'h03, 1'b0);           // period 0x3FF
        do_write(8'h27, 8'h05, 1'b0);           // load 0x3FF
        do_write(8'h27, 8'h15, 1'b1);           // tick overflows, clear wins
        check_all("R8 clear wins", 8'h00, 2'd0);
        run_ticks(1);                           // reloaded 0x3FF overflows again
        check_all("R4 every tick at period 1023", 8'h01, 2'd0);

        // R3: restart reloads the period instead of resuming
        do_write(8'h27, 8'h14, 1'b0);
        do_write(8'h25, 8'h00, 1'b0);           // period 0x3FC
        do_write(8'h27, 8'h05, 1'b0);
        run_ticks(2);                           // count 0x3FE
        do_write(8'h27, 8'h04, 1'b0);           // stop
        run_ticks(4);
        check_all("R3 frozen while stopped", 8'h00, 2'd0);
        do_write(8'h27, 8'h05, 1'b0);           // restart, reload 0x3FC
        run_ticks(3);
        check_all("R3 restart reloads", 8'h00, 2'd0);
        run_ticks(1);
        check_all("R4 overflow on tick 1024-P", 8'h01, 2'd0);

        // R11: reset mid-run clears everything
        do_write(8'h27, 8'hC5, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R11 reset mid-run", 8'h00, 2'd0);
        rst_n = 1'b1;
        run_ticks(1030);
        check_all("R11 timers stopped after reset", 8'h00, 2'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule